// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers event pulses from the peripherals of a small controller into one 8-bit flag word. The peripherals are an ADC, a UART receiver and transmitter, a synchronous serial port, a capture/compare unit and two timers. A CPU reads the word and writes it over a simple register bus with a read strobe, a write strobe, write data and read data. Five of the flags are sticky. Each one latches on its event and stays set until software writes a zero to it. Software may also write a one to raise a flag for test.

The two UART flags work differently. They follow the state of the UART's one-entry buffers. The receive flag shows that received data is waiting, and the transmit flag shows that the transmit buffer can take a byte. Both are read-only from the bus. They clear as a side effect of the buffer being read or written.

Every flag sets when its event occurs, whatever the state of its enable bit. A registered interrupt request is formed from the flags, an 8-bit per-flag enable vector and a global enable.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, every flag is 0, `reg_rdata` is 0x00 and `irq_req` is 0.
- R2: Bit 7 is not implemented. It always reads 0, and writing 1 to it has no effect.
- R3: The sticky flags sit at fixed bit positions: ADC done at bit 6, serial port done at bit 3, capture/compare at bit 2, timer2 match at bit 1 and timer1 overflow at bit 0. A single-cycle event pulse sets its flag on the next clock edge, whatever the values of `irq_en` and `irq_glb_en`. The flag then stays set until it is written.
- R4: A bus write loads each sticky flag from its data bit. Writing 0 clears the flag and writing 1 sets it.
- R5: If an event and a bus write of 0 reach the same sticky flag in the same cycle, the flag ends up set.
- R6: Bit 5 is the receive flag. `rx_push` sets it and `rx_pop` clears it. When both arrive in the same cycle, the flag ends up set.
- R7: Bit 4 is the transmit flag. `tx_drain` sets it and `tx_fill` clears it. When both arrive in the same cycle, the flag ends up clear. Bus writes never change bit 4 or bit 5.
- R8: `ccp_mode` selects how the capture/compare flag sets. With mode 0 (capture) only `ccp_capture` sets it. With mode 1 (compare) only `ccp_match` sets it. With mode 2 (PWM) and mode 3 (off), no event sets it.
- R9: `irq_req` is a register. It takes the value of `irq_glb_en` AND (the OR over bits of flag AND `irq_en`), so it rises one cycle after a flag becomes visible on the bus.
- R10: A read strobe captures the flag word, as it stands before the edge, into `reg_rdata` on the clock edge. Without a read strobe, `reg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| adc_done | input | 1 | ADC conversion-done pulse |
| ssp_done | input | 1 | Serial port transfer-done pulse |
| ccp_mode | input | 2 | Capture/compare mode: 0 capture, 1 compare, 2 PWM, 3 off |
| ccp_capture | input | 1 | Timer capture pulse |
| ccp_match | input | 1 | Compare match pulse |
| tmr2_match | input | 1 | Timer2 period match pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| rx_push | input | 1 | Received byte loaded into the receive buffer |
| rx_pop | input | 1 | Receive buffer read by the CPU |
| tx_drain | input | 1 | Transmit buffer moved to the shifter (buffer now empty) |
| tx_fill | input | 1 | Transmit buffer written by the CPU |
| irq_en | input | 8 | Per-flag interrupt enables |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters. These give the full 8-bit map with five sticky flags, set priority on the receive flag and write priority on the transmit flag. With that build, both same-cycle collision orders on the two UART flags can be reached, along with the race between an event and a bus clear on a sticky flag. The same build also reaches every capture/compare mode, including the two modes in which no event may set the flag.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int FLAG_W   = 8;
    localparam int STICKY_N = 5;

    localparam int B_TMR1 = 0;
    localparam int B_TMR2 = 1;
    localparam int B_CCP  = 2;
    localparam int B_SSP  = 3;
    localparam int B_TX   = 4;
    localparam int B_RX   = 5;
    localparam int B_ADC  = 6;
    localparam int B_RSVD = 7;

    typedef enum logic [1:0] {
        CCP_CAPTURE = 2'd0,
        CCP_COMPARE = 2'd1,
        CCP_PWM     = 2'd2,
        CCP_OFF     = 2'd3
    } ccp_mode_e;

    // Bit position in the flag word of sticky flag number idx
    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return B_TMR1;
            1:       return B_TMR2;
            2:       return B_CCP;
            3:       return B_SSP;
            default: return B_ADC;
        endcase
    endfunction

endpackage

// File: rtl/ccp_event_sel.sv
module ccp_event_sel
    import irq_flag_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       capture_ev,
    input  logic       match_ev,
    output logic       flag_ev
);

    ccp_mode_e mode_e;

    always_comb begin
        mode_e = ccp_mode_e'(mode);
        unique case (mode_e)
            CCP_CAPTURE: flag_ev = capture_ev;
            CCP_COMPARE: flag_ev = match_ev;
            default:     flag_ev = 1'b0;
        endcase
    end

endmodule

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] flags
);

    typedef struct packed {
        logic [N-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en)     st_d.flag[i] = wr_val[i];
            if (set_ev[i]) st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R3
        sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[g] |=> flags[g]);
        // R3
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !wr_en) |=> flags[g]);
        // R4
        sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_val[g] && !set_ev[g]) |=> !flags[g]);
    end

endmodule

// File: rtl/uart_level_flag.sv
module uart_level_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic flag
);

    typedef struct packed {
        logic lvl;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (SET_WINS) begin
            if (clr_pulse) st_d.lvl = 1'b0;
            if (set_pulse) st_d.lvl = 1'b1;
        end else begin
            if (set_pulse) st_d.lvl = 1'b1;
            if (clr_pulse) st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.lvl;

    // R6
    lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse && !clr_pulse) |=> flag);
    // R7
    lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !set_pulse) |=> !flag);
    // R7
    lvl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_pulse && !clr_pulse) |=> $stable(flag));

endmodule

// File: rtl/irq_request_gen.sv
module irq_request_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    input  logic [W-1:0] en,
    input  logic         glb_en,
    output logic         irq
);

    typedef struct packed {
        logic req;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = glb_en & (|(flags & en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.req;

    // R9
    glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq);
    // R9
    no_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en) == '0) |=> !irq);

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata,
    input  logic              adc_done,
    input  logic              ssp_done,
    input  logic [1:0]        ccp_mode,
    input  logic              ccp_capture,
    input  logic              ccp_match,
    input  logic              tmr2_match,
    input  logic              tmr1_ovf,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              tx_drain,
    input  logic              tx_fill,
    input  logic [FLAG_W-1:0] irq_en,
    input  logic              irq_glb_en,
    output logic              irq_req
);

    typedef struct packed {
        logic [FLAG_W-1:0] rdata;
    } bus_t;

    bus_t bus_d, bus_q;

    logic                ccp_ev;
    logic [STICKY_N-1:0] sticky_set;
    logic [STICKY_N-1:0] sticky_wval;
    logic [STICKY_N-1:0] sticky_flags;
    logic                rx_flag;
    logic                tx_flag;
    logic [FLAG_W-1:0]   flag_word;

    ccp_event_sel u_ccp_sel (
        .mode       (ccp_mode),
        .capture_ev (ccp_capture),
        .match_ev   (ccp_match),
        .flag_ev    (ccp_ev)
    );

    logic [FLAG_W-1:0] ev_word;
    assign ev_word = {1'b0, adc_done, 1'b0, 1'b0, ssp_done, ccp_ev, tmr2_match, tmr1_ovf};

    for (genvar g = 0; g < STICKY_N; g++) begin : g_map
        localparam int POS = sticky_pos(g);
        assign sticky_set[g]  = ev_word[POS];
        assign sticky_wval[g] = reg_wdata[POS];
        assign flag_word[POS] = sticky_flags[g];
    end

    assign flag_word[B_RX]   = rx_flag;
    assign flag_word[B_TX]   = tx_flag;
    assign flag_word[B_RSVD] = 1'b0;

    sticky_flag_bank #(.N(STICKY_N)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (sticky_set),
        .wr_en  (reg_wr),
        .wr_val (sticky_wval),
        .flags  (sticky_flags)
    );

    uart_level_flag #(.SET_WINS(1'b1)) u_rx_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (rx_push),
        .clr_pulse (rx_pop),
        .flag      (rx_flag)
    );

    uart_level_flag #(.SET_WINS(1'b0)) u_tx_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (tx_drain),
        .clr_pulse (tx_fill),
        .flag      (tx_flag)
    );

    irq_request_gen #(.W(FLAG_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (flag_word),
        .en     (irq_en),
        .glb_en (irq_glb_en),
        .irq    (irq_req)
    );

    always_comb begin
        bus_d = bus_q;
        if (reg_rd) bus_d.rdata = flag_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign reg_rdata = bus_q.rdata;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[B_RSVD]);
    // R8
    ccp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ccp_mode[1]) && !(reg_wr && reg_wdata[B_CCP])) |=> !$rose(flag_word[B_CCP]));
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    // R7
    bus_no_uart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !rx_push && !rx_pop) |=> $stable(flag_word[B_RX]));

endmodule

// File: tb/irq_flag_reg_test.sv
module irq_flag_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       adc_done = 0, ssp_done = 0, ccp_capture = 0, ccp_match = 0;
    logic [1:0] ccp_mode = 2'd0;
    logic       tmr2_match = 0, tmr1_ovf = 0;
    logic       rx_push = 0, rx_pop = 0, tx_drain = 0, tx_fill = 0;
    logic [7:0] irq_en = '0;
    logic       irq_glb_en = 0;
    logic       irq_req;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_d = 1'b0;

    always #2 clk = ~clk;

    irq_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_done(adc_done),
        .ssp_done(ssp_done), .ccp_mode(ccp_mode), .ccp_capture(ccp_capture),
        .ccp_match(ccp_match), .tmr2_match(tmr2_match), .tmr1_ovf(tmr1_ovf),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_drain(tx_drain), .tx_fill(tx_fill),
        .irq_en(irq_en), .irq_glb_en(irq_glb_en), .irq_req(irq_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check1(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected read value and strobes a read
    task automatic do_read(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        tick();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    always @(posedge clk) rd_d <= reg_rd;

    // Monitor: compares every read result against the scoreboard
    always @(negedge clk) begin
        if (rd_d) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected read, actual %02h expected none", reg_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, reg_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check1(reg_rdata == 8'h00, 1'b1, "R1 rdata after reset");
        check1(irq_req, 1'b0, "R1 irq after reset");
        rst_n = 1'b1;
        tick();
        do_read(8'h00, "R1 flags after reset");

        // R3 sticky set with enables off
        adc_done = 1; tick(); adc_done = 0;
        do_read(8'h40, "R3 adc flag");
        check1(irq_req, 1'b0, "R3 flag set without irq");
        tmr1_ovf = 1; tmr2_match = 1; ssp_done = 1; tick();
        tmr1_ovf = 0; tmr2_match = 0; ssp_done = 0;
        repeat (4) tick();
        do_read(8'h4B, "R3 flags stay set");

        // R4 clear by write 0, set by write 1; R2 and R7 bus ignores bits 7,5,4
        do_write(8'h00);
        do_read(8'h00, "R4 write zero clears");
        do_write(8'hFF);
        do_read(8'h4F, "R4 R2 R7 write ones");
        do_write(8'h00);

        // R5 set beats clear
        tmr1_ovf = 1; reg_wr = 1; reg_wdata = 8'h00; tick();
        tmr1_ovf = 0; reg_wr = 0;
        do_read(8'h01, "R5 event beats clear");
        do_write(8'h00);

        // R10 hold without read strobe
        repeat (2) tick();
        check1(reg_rdata == 8'h01, 1'b1, "R10 rdata held");
        do_read(8'h00, "R10 fresh read");

        // R6 receive flag
        rx_push = 1; tick(); rx_push = 0;
        do_read(8'h20, "R6 rx push");
        rx_pop = 1; tick(); rx_pop = 0;
        do_read(8'h00, "R6 rx pop");
        rx_push = 1; rx_pop = 1; tick(); rx_push = 0; rx_pop = 0;
        do_read(8'h20, "R6 push wins");
        rx_pop = 1; tick(); rx_pop = 0;

        // R7 transmit flag
        tx_drain = 1; tick(); tx_drain = 0;
        do_read(8'h10, "R7 tx drain");
        do_write(8'h00);
        do_read(8'h10, "R7 bus write ignored");
        tx_fill = 1; tick(); tx_fill = 0;
        do_read(8'h00, "R7 tx fill");
        tx_drain = 1; tx_fill = 1; tick(); tx_drain = 0; tx_fill = 0;
        do_read(8'h00, "R7 fill wins");

        // R8 capture/compare modes
        ccp_mode = 2'd0; ccp_match = 1; tick(); ccp_match = 0;
        do_read(8'h00, "R8 capture ignores match");
        ccp_capture = 1; tick(); ccp_capture = 0;
        do_read(8'h04, "R8 capture sets");
        do_write(8'h00);
        ccp_mode = 2'd1; ccp_capture = 1; tick(); ccp_capture = 0;
        do_read(8'h00, "R8 compare ignores capture");
        ccp_match = 1; tick(); ccp_match = 0;
        do_read(8'h04, "R8 compare sets");
        do_write(8'h00);
        ccp_mode = 2'd2; ccp_match = 1; ccp_capture = 1; tick();
        ccp_mode = 2'd3; tick(); ccp_match = 0; ccp_capture = 0;
        do_read(8'h00, "R8 pwm and off never set");

        // R9 interrupt request
        irq_en = 8'h01; irq_glb_en = 1;
        tmr1_ovf = 1; tick(); tmr1_ovf = 0;
        check1(irq_req, 1'b0, "R9 one cycle latency");
        tick();
        check1(irq_req, 1'b1, "R9 irq raised");
        irq_en = 8'h02; tick();
        check1(irq_req, 1'b0, "R9 disabled flag");
        irq_en = 8'h01; irq_glb_en = 0; tick();
        check1(irq_req, 1'b0, "R9 global gate");
        irq_glb_en = 1; tick();
        check1(irq_req, 1'b1, "R9 global reopened");
        do_write(8'h00);
        tick();
        check1(irq_req, 1'b0, "R9 cleared flag drops irq");
        irq_en = 8'h80; do_write(8'h80); tick();
        check1(irq_req, 1'b0, "R2 bit 7 cannot request");

        tick();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule